// File: doc/BRIEF.md
# Indirect Jump Target Predictor (tagless, history-hashed)

This block predicts where an indirect jump will go. A fetch lookup presents the fetch address together with a global record of recent conditional-branch outcomes. The block hashes the two into an index, reads one table entry and returns the stored 32-bit target in the same cycle. A separate branch-type lookup runs alongside and reports whether the fetched instruction is an indirect jump. The stored target counts as a prediction only when that lookup says indirect jump and not return.

Because the history can move on before the jump resolves, the lookup hands its index back to the caller. On resolution the caller returns that index on the update port with the computed target, and the entry at that index is overwritten. Several table entries can hold targets for the same static jump when it is reached through different histories. An index-mode input selects one of four ways to form the index. Both stream ports are valid/ready. Ready is always high, so neither port ever applies back-pressure, and a transfer happens on every cycle in which valid is high.

Top module: `tgt_predictor`

## Requirements
- R1: Reset clears every entry to zero. A lookup of an entry that has never been written returns target 0.
- R2: With `idx_mode` = 0 (folded mode), the index is `lk_pc[10:2] XOR ghist[8:0]`.
- R3: With `idx_mode` = 1 (history-only mode), the index is `ghist[8:0]`.
- R4: With `idx_mode` = 2 (one-bank-bit mode), the index is `{lk_pc[2], ghist[7:0]}`. The address bit picks a half of the table and the history picks the entry within it.
- R5: With `idx_mode` = 3 (two-bank-bit mode), the index is `{lk_pc[3:2], ghist[6:0]}`.
- R6: Bits 1:0 of `lk_pc` never affect the index.
- R7: `pred_valid` is high in the same cycle as the lookup exactly when `lk_valid`, `lk_is_ind` are high and `lk_is_ret` is low. `pred_target` carries the entry's value when `pred_valid` is high and is 0 otherwise. `pred_index` always shows the formed index.
- R8: An update with `upd_valid` high and `upd_is_ret` low writes `upd_target` at `upd_index`. Lookups see the new value from the next cycle on.
- R9: An update with `upd_is_ret` high leaves the table unchanged.
- R10: When a lookup and a write hit the same index in the same cycle, the lookup returns the value held before the write.
- R11: `lk_ready` and `upd_ready` are always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_mode | input | 2 | Index formation mode (0..3, see R2-R5 individually) |
| ghist | input | 9 | Global conditional-branch outcome history, newest in bit 0 |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup accepted (always 1) |
| lk_pc | input | 32 | Fetch address of the instruction |
| lk_is_ind | input | 1 | Branch-type lookup reports an indirect jump |
| lk_is_ret | input | 1 | Branch-type lookup reports a return |
| pred_valid | output | 1 | Target prediction is usable |
| pred_target | output | 32 | Predicted target |
| pred_index | output | 9 | Index formed for this lookup, to be returned at update |
| upd_valid | input | 1 | Update request valid |
| upd_ready | output | 1 | Update accepted (always 1) |
| upd_is_ret | input | 1 | Resolved instruction is a return |
| upd_index | input | 9 | Index captured at lookup |
| upd_target | input | 32 | Computed target |

## Verification
Every lookup result (`pred_valid`, `pred_target`, `pred_index`) is combinational and due in the lookup's own cycle. An update becomes visible one clock edge later. The bench drives all inputs just after a falling edge and samples the outputs 1 ns later, well before the next rising edge. Its reference table is updated only after that sample, so a same-cycle read and write is compared against the old content. Any later read is compared against the written value.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
  typedef enum logic [1:0] {
    MODE_FOLD  = 2'd0,
    MODE_HIST  = 2'd1,
    MODE_BANK1 = 2'd2,
    MODE_BANK2 = 2'd3
  } idx_mode_e;

  localparam int ALIGN_BITS = 2;
endpackage

// File: rtl/tgt_idx_hash.sv
module tgt_idx_hash
  import tgt_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  idx_mode_e        mode,
  input  logic [PC_W-1:0]  pc,
  input  logic [IDX_W-1:0] hist,
  output logic [IDX_W-1:0] idx
);
  localparam int NMODES = 4;

  logic [IDX_W-1:0] pcw;
  logic [IDX_W-1:0] cand [NMODES];

  assign pcw     = pc[ALIGN_BITS +: IDX_W];
  assign cand[0] = pcw ^ hist;
  assign cand[1] = hist;

  for (genvar k = 1; k <= 2; k++) begin : g_bank
    assign cand[1+k] = {pcw[k-1:0], hist[IDX_W-1-k:0]};
  end

  assign idx = cand[mode];

  // R2
  fold_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FOLD) |-> ((idx ^ hist) == pc[ALIGN_BITS +: IDX_W]));

  // R5
  bank_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BANK2) |-> (idx[IDX_W-1 -: 2] == pc[ALIGN_BITS +: 2]));
endmodule

// File: rtl/tgt_table.sv
module tgt_table #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     ridx,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [AW-1:0]     widx,
  input  logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];

  // R8
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(widx)] == $past(wdata)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (mem[$past(widx)] == $past(mem[widx])));

  // R1
  clear_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rdata == '0));
endmodule

// File: rtl/tgt_predictor.sv
module tgt_predictor
  import tgt_pkg::*;
#(
  parameter int ENTRIES = 512,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        idx_mode,
  input  logic [IDX_W-1:0]  ghist,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic              lk_is_ind,
  input  logic              lk_is_ret,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_target,
  output logic [IDX_W-1:0]  pred_index,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic              upd_is_ret,
  input  logic [IDX_W-1:0]  upd_index,
  input  logic [ADDR_W-1:0] upd_target
);
  logic [IDX_W-1:0]  look_idx;
  logic [ADDR_W-1:0] entry;
  logic              wr_en;
  logic              use_pred;

  tgt_idx_hash #(.IDX_W(IDX_W), .PC_W(ADDR_W)) u_hash (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (idx_mode_e'(idx_mode)),
    .pc   (lk_pc),
    .hist (ghist),
    .idx  (look_idx)
  );

  assign wr_en = upd_valid && !upd_is_ret;

  tgt_table #(.DEPTH(ENTRIES), .DATA_W(ADDR_W)) u_tbl (
    .clk  (clk),
    .rst_n(rst_n),
    .ridx (look_idx),
    .rdata(entry),
    .we   (wr_en),
    .widx (upd_index),
    .wdata(upd_target)
  );

  assign use_pred    = lk_valid && lk_is_ind && !lk_is_ret;
  assign pred_valid  = use_pred;
  assign pred_target = use_pred ? entry : '0;
  assign pred_index  = look_idx;
  assign lk_ready    = 1'b1;
  assign upd_ready   = 1'b1;

  // R7
  ret_no_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_is_ret || !lk_is_ind) |-> (!pred_valid && pred_target == '0));
endmodule

// File: tb/tb_tgt_predictor.sv
module tb_tgt_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  idx_mode = '0;
  logic [8:0]  ghist = '0;
  logic        lk_valid = 1'b0, lk_is_ind = 1'b0, lk_is_ret = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_ready, pred_valid, upd_ready;
  logic [31:0] pred_target;
  logic [8:0]  pred_index;
  logic        upd_valid = 1'b0, upd_is_ret = 1'b0;
  logic [8:0]  upd_index = '0;
  logic [31:0] upd_target = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] model [512];
  logic [8:0]  last_idx = '0;

  always #4 clk = ~clk;

  tgt_predictor dut (
    .clk(clk), .rst_n(rst_n), .idx_mode(idx_mode), .ghist(ghist),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .lk_is_ind(lk_is_ind), .lk_is_ret(lk_is_ret),
    .pred_valid(pred_valid), .pred_target(pred_target), .pred_index(pred_index),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_is_ret(upd_is_ret),
    .upd_index(upd_index), .upd_target(upd_target)
  );

  function automatic logic [8:0] exp_idx(logic [1:0] m, logic [31:0] pc, logic [8:0] h);
    case (m)
      2'd0:    return pc[10:2] ^ h;
      2'd1:    return h;
      2'd2:    return {pc[2], h[7:0]};
      default: return {pc[3:2], h[6:0]};
    endcase
  endfunction

  function automatic string mode_req(logic [1:0] m);
    case (m)
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(logic [1:0] m, logic [31:0] pc, logic [8:0] h,
                      logic lv, logic ind, logic ret,
                      logic uv, logic uret, logic [8:0] ui, logic [31:0] ut);
    logic [8:0]  ei;
    logic        ev;
    logic [31:0] et;
    @(negedge clk);
    idx_mode = m; lk_pc = pc; ghist = h; lk_valid = lv; lk_is_ind = ind; lk_is_ret = ret;
    upd_valid = uv; upd_is_ret = uret; upd_index = ui; upd_target = ut;
    #1;
    ei = exp_idx(m, pc, h);
    ev = lv && ind && !ret;
    et = ev ? model[ei] : 32'h0;
    check(pred_index == ei, mode_req(m), {23'h0, pred_index}, {23'h0, ei});
    check(pred_valid == ev, "R7", {31'h0, pred_valid}, {31'h0, ev});
    check(pred_target == et, "R8", pred_target, et);
    check(lk_ready && upd_ready, "R11", {30'h0, lk_ready, upd_ready}, 32'h3);
    last_idx = pred_index;
    if (uv && !uret) model[ui] = ut;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] ia, ib;
    void'($urandom(32'd2024));
    for (int i = 0; i < 512; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: never-written entry reads zero after reset
    step(2'd0, 32'h0000_1234, 9'h0A5, 1, 1, 0, 0, 0, 9'h0, 32'h0);
    check(pred_target == 32'h0, "R1", pred_target, 32'h0);

    // R10: same-cycle read and write at index 0x055 returns old value
    step(2'd1, 32'h0, 9'h055, 1, 1, 0, 1, 0, 9'h055, 32'hCAFE_0040);
    check(pred_target == 32'h0, "R10", pred_target, 32'h0);
    // R8: visible the next cycle
    step(2'd1, 32'h0, 9'h055, 1, 1, 0, 0, 0, 9'h0, 32'h0);
    check(pred_target == 32'hCAFE_0040, "R8", pred_target, 32'hCAFE_0040);

    // R9: return update ignored
    step(2'd1, 32'h0, 9'h000, 1, 0, 0, 1, 1, 9'h055, 32'h1111_2222);
    step(2'd1, 32'h0, 9'h055, 1, 1, 0, 0, 0, 9'h0, 32'h0);
    check(pred_target == 32'hCAFE_0040, "R9", pred_target, 32'hCAFE_0040);

    // R7: return lookup gives no prediction
    step(2'd1, 32'h0, 9'h055, 1, 1, 1, 0, 0, 9'h0, 32'h0);
    check(!pred_valid && pred_target == 32'h0, "R7", pred_target, 32'h0);

    // R6: low address bits do not move the index, in every mode
    for (int m = 0; m < 4; m++) begin
      step(2'(m), 32'h0000_0AB0, 9'h133, 1, 1, 0, 0, 0, 9'h0, 32'h0);
      ia = pred_index;
      step(2'(m), 32'h0000_0AB3, 9'h133, 1, 1, 0, 0, 0, 9'h0, 32'h0);
      ib = pred_index;
      check(ia == ib, "R6", {23'h0, ib}, {23'h0, ia});
    end

    // Random traffic with write-backs at indices formed at fetch
    for (int n = 0; n < 4000; n++) begin
      logic [8:0] ui;
      ui = ($urandom % 2) ? last_idx : 9'($urandom);
      step(2'($urandom), $urandom, 9'($urandom),
           ($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 8) == 0,
           ($urandom % 2) == 0, ($urandom % 8) == 0, ui, $urandom);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule